// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block carries the running calendar words (sub-second count, time of day, date) from the slow timekeeping clock domain into the faster bus clock domain. It does this through a set of shadow registers that a bus read returns. The timekeeping side issues a copy request on a fixed cadence of two timekeeping clock periods. A toggle synchronizer carries each request into the bus domain. There all three shadow words are loaded in the same bus cycle, so a read never sees a time taken at one moment and a date taken at another. Each copy raises a "shadows fresh" flag. Software clears the flag with a one-cycle strobe and then waits for it to rise again before it trusts a read.

While the device sits in a low-power mode, the copy cadence stops and the shadows hold their last contents. When the mode ends, the cadence restarts from its beginning, so a new copy arrives within two timekeeping periods plus the synchronizer latency. A bypass control makes reads return the live calendar words combinationally, with no synchronizer wait. The shadow path gives correct results only when the bus clock runs at least seven times faster than the timekeeping clock. With that ratio the live words stay steady for the few bus cycles between a copy request and its capture.

Top module: `cal_shadow_sync`

## Requirements
- R1: While sysRstN is low, and right after it is released, the shadow words read back as zero (with bypassShadow low) and syncFlag is low.
- R2: With lowPower low, a copy happens once every two rtcClk periods. Each copy sets syncFlag and leaves the shadows no more than three rtcClk ticks behind the live calendar.
- R3: The three shadow words are loaded in the same bus cycle from the same timekeeping instant, so the values read back always belong together.
- R4: While lowPower is high, no copy takes place. The shadow words and syncFlag stay unchanged.
- R5: After lowPower falls, a fresh copy lands and syncFlag rises within two rtcClk periods plus five busClk cycles.
- R6: With bypassShadow low, rdSubsec, rdTime and rdDate return the shadow words. With bypassShadow high, they return liveSubsec, liveTime and liveDate unchanged in the same cycle.
- R7: A one-cycle high syncFlagClr clears syncFlag on the next busClk edge. If a copy lands in that same cycle, the copy wins and syncFlag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtcClk | input | 1 | Timekeeping clock |
| busClk | input | 1 | Bus clock, at least seven times rtcClk |
| sysRstN | input | 1 | Asynchronous active-low system reset |
| liveSubsec | input | SUBSEC_W | Live sub-second count, changes on rtcClk |
| liveTime | input | TIME_W | Live time-of-day word, changes on rtcClk |
| liveDate | input | DATE_W | Live date word, changes on rtcClk |
| lowPower | input | 1 | Low-power mode indication, rtcClk domain |
| bypassShadow | input | 1 | 1: reads return live words directly |
| syncFlagClr | input | 1 | One-cycle strobe that clears syncFlag, busClk domain |
| rdSubsec | output | SUBSEC_W | Sub-second read data |
| rdTime | output | TIME_W | Time read data |
| rdDate | output | DATE_W | Date read data |
| syncFlag | output | 1 | Shadows-fresh flag |

## Verification
The hardest case to reach is a flag clear that lands in the same bus cycle as a copy, because the copy strobe is internal. The bench works around this with a 10:1 integer clock ratio, which spaces copies exactly 20 bus cycles apart. It aligns itself by clearing the flag and watching for it to rise. Then it sweeps the clear strobe across five offsets around the next copy. Exactly one offset must leave the flag high. Each live word is a distinct function of one tick counter, so the bench can check that the three shadows belong together and how recent they are.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  // Strobes passed from the control unit to the datapath, bus domain
  typedef struct packed {
    logic copy;     // load all shadows this cycle
    logic flagClr;  // software clear of the fresh flag
  } shadowStrobe_t;
endpackage

// File: rtl/cal_shadow_ctrl.sv
module cal_shadow_ctrl
  import cal_shadow_pkg::*;
#(
  parameter int CADENCE     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rtcClk,
  input  logic          busClk,
  input  logic          sysRstN,
  input  logic          lowPower,
  input  logic          syncFlagClr,
  output shadowStrobe_t strb
);
  localparam int CNT_W = (CADENCE > 1) ? $clog2(CADENCE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CADENCE - 1);

  // Timekeeping domain: cadence counter and request toggle
  logic [CNT_W-1:0] cadCnt;
  logic             reqTgl;

  always_ff @(posedge rtcClk or negedge sysRstN) begin
    if (!sysRstN) begin
      cadCnt <= '0;
      reqTgl <= 1'b0;
    end else if (lowPower) begin
      cadCnt <= '0;
    end else if (cadCnt == LAST) begin
      cadCnt <= '0;
      reqTgl <= ~reqTgl;
    end else begin
      cadCnt <= cadCnt + 1'b1;
    end
  end

  // R4
  lowpwr_hold_chk: assert property (@(posedge rtcClk) disable iff (!sysRstN)
    lowPower |=> $stable(reqTgl));
  // R2
  cadence_gap_chk: assert property (@(posedge rtcClk) disable iff (!sysRstN)
    !$stable(reqTgl) |=> $stable(reqTgl));

  // Bus domain: toggle synchronizer and edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   seenTgl;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge busClk or negedge sysRstN) begin
        if (!sysRstN) syncQ <= '0;
        else          syncQ <= reqTgl;
      end
    end else begin : g_chain
      always_ff @(posedge busClk or negedge sysRstN) begin
        if (!sysRstN) syncQ <= '0;
        else          syncQ <= {syncQ[SYNC_STAGES-2:0], reqTgl};
      end
    end
  endgenerate

  always_ff @(posedge busClk or negedge sysRstN) begin
    if (!sysRstN) seenTgl <= 1'b0;
    else          seenTgl <= syncQ[SYNC_STAGES-1];
  end

  always_comb begin
    strb.copy    = syncQ[SYNC_STAGES-1] ^ seenTgl;
    strb.flagClr = syncFlagClr;
  end

  // R2
  copy_single_chk: assert property (@(posedge busClk) disable iff (!sysRstN)
    strb.copy |=> !strb.copy);
endmodule

// File: rtl/cal_shadow_data.sv
module cal_shadow_data
  import cal_shadow_pkg::*;
#(
  parameter int SUBSEC_W = 16,
  parameter int TIME_W   = 24,
  parameter int DATE_W   = 24
) (
  input  logic                busClk,
  input  logic                sysRstN,
  input  shadowStrobe_t       strb,
  input  logic [SUBSEC_W-1:0] liveSubsec,
  input  logic [TIME_W-1:0]   liveTime,
  input  logic [DATE_W-1:0]   liveDate,
  input  logic                bypassShadow,
  output logic [SUBSEC_W-1:0] rdSubsec,
  output logic [TIME_W-1:0]   rdTime,
  output logic [DATE_W-1:0]   rdDate,
  output logic                syncFlag
);
  logic [SUBSEC_W-1:0] shSubsec;
  logic [TIME_W-1:0]   shTime;
  logic [DATE_W-1:0]   shDate;

  always_ff @(posedge busClk or negedge sysRstN) begin
    if (!sysRstN) begin
      shSubsec <= '0;
      shTime   <= '0;
      shDate   <= '0;
    end else if (strb.copy) begin
      shSubsec <= liveSubsec;
      shTime   <= liveTime;
      shDate   <= liveDate;
    end
  end

  always_ff @(posedge busClk or negedge sysRstN) begin
    if (!sysRstN)          syncFlag <= 1'b0;
    else if (strb.copy)    syncFlag <= 1'b1;
    else if (strb.flagClr) syncFlag <= 1'b0;
  end

  always_comb begin
    rdSubsec = bypassShadow ? liveSubsec : shSubsec;
    rdTime   = bypassShadow ? liveTime   : shTime;
    rdDate   = bypassShadow ? liveDate   : shDate;
  end

  // R3
  joint_load_chk: assert property (@(posedge busClk) disable iff (!sysRstN)
    strb.copy |=> (shSubsec == $past(liveSubsec)) && (shTime == $past(liveTime))
                  && (shDate == $past(liveDate)));
  // R4
  shadow_hold_chk: assert property (@(posedge busClk) disable iff (!sysRstN)
    !strb.copy |=> $stable(shSubsec) && $stable(shTime) && $stable(shDate));
  // R7
  copy_wins_chk: assert property (@(posedge busClk) disable iff (!sysRstN)
    strb.copy |=> syncFlag);
  // R7
  flag_clear_chk: assert property (@(posedge busClk) disable iff (!sysRstN)
    (strb.flagClr && !strb.copy) |=> !syncFlag);
endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
  import cal_shadow_pkg::*;
#(
  parameter int SUBSEC_W    = 16,
  parameter int TIME_W      = 24,
  parameter int DATE_W      = 24,
  parameter int CADENCE     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rtcClk,
  input  logic                busClk,
  input  logic                sysRstN,
  input  logic [SUBSEC_W-1:0] liveSubsec,
  input  logic [TIME_W-1:0]   liveTime,
  input  logic [DATE_W-1:0]   liveDate,
  input  logic                lowPower,
  input  logic                bypassShadow,
  input  logic                syncFlagClr,
  output logic [SUBSEC_W-1:0] rdSubsec,
  output logic [TIME_W-1:0]   rdTime,
  output logic [DATE_W-1:0]   rdDate,
  output logic                syncFlag
);
  shadowStrobe_t strb;

  cal_shadow_ctrl #(
    .CADENCE(CADENCE), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .rtcClk(rtcClk), .busClk(busClk), .sysRstN(sysRstN),
    .lowPower(lowPower), .syncFlagClr(syncFlagClr), .strb(strb)
  );

  cal_shadow_data #(
    .SUBSEC_W(SUBSEC_W), .TIME_W(TIME_W), .DATE_W(DATE_W)
  ) u_data (
    .busClk(busClk), .sysRstN(sysRstN), .strb(strb),
    .liveSubsec(liveSubsec), .liveTime(liveTime), .liveDate(liveDate),
    .bypassShadow(bypassShadow),
    .rdSubsec(rdSubsec), .rdTime(rdTime), .rdDate(rdDate), .syncFlag(syncFlag)
  );
endmodule

// File: tb/cal_shadow_sync_tb.sv
module cal_shadow_sync_tb;
  logic busClk = 1'b0;
  logic rtcClk = 1'b0;
  logic sysRstN = 1'b0;
  logic lowPower = 1'b0;
  logic bypassShadow = 1'b0;
  logic syncFlagClr = 1'b0;
  logic [15:0] tick = '0;
  logic [15:0] rdSubsec;
  logic [23:0] rdTime, rdDate, liveTime, liveDate;
  logic        syncFlag;
  int checks = 0;
  int errors = 0;

  always #10 busClk = ~busClk;
  initial begin
    #7;
    forever begin rtcClk = ~rtcClk; #100; end
  end

  // Live words are distinct functions of one tick count
  function automatic logic [23:0] timeOf(logic [15:0] n);
    return {n[7:0] ^ 8'h3C, n};
  endfunction
  function automatic logic [23:0] dateOf(logic [15:0] n);
    return {~n, n[15:8]};
  endfunction

  always @(posedge rtcClk or negedge sysRstN)
    if (!sysRstN) tick <= '0; else tick <= tick + 16'd1;
  assign liveTime = timeOf(tick);
  assign liveDate = dateOf(tick);

  cal_shadow_sync u_dut (
    .rtcClk(rtcClk), .busClk(busClk), .sysRstN(sysRstN),
    .liveSubsec(tick), .liveTime(liveTime), .liveDate(liveDate),
    .lowPower(lowPower), .bypassShadow(bypassShadow), .syncFlagClr(syncFlagClr),
    .rdSubsec(rdSubsec), .rdTime(rdTime), .rdDate(rdDate), .syncFlag(syncFlag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulseClr();
    syncFlagClr = 1'b1;
    @(negedge busClk);
    syncFlagClr = 1'b0;
  endtask

  // Shadows belong together and lag the live tick by at most three
  task automatic chkShadow(string req);
    chk({req, " time"}, rdTime, timeOf(rdSubsec));
    chk({req, " date"}, rdDate, dateOf(rdSubsec));
    chk({req, " age"}, 32'((tick - rdSubsec) <= 16'd3), 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] snapS;
    logic [23:0] snapT, snapD;
    int hits;
    void'($urandom(32'd1234));
    repeat (8) @(negedge busClk);
    // R1: reset state
    chk("R1 rst subsec", rdSubsec, 0);
    chk("R1 rst time", rdTime, 0);
    chk("R1 rst flag", syncFlag, 0);
    sysRstN = 1'b1;
    @(negedge busClk);
    chk("R1 post subsec", rdSubsec, 0);
    chk("R1 post date", rdDate, 0);
    chk("R1 post flag", syncFlag, 0);
    repeat (60) @(negedge busClk);
    // R2: copies running
    chk("R2 flag set", syncFlag, 1);
    chkShadow("R2");

    // Random reads, mixing the two read paths
    for (int i = 0; i < 300; i++) begin
      bypassShadow = ($urandom % 3) == 0;
      repeat (1 + ($urandom % 25)) @(negedge busClk);
      if (bypassShadow) begin
        // R6: live path
        chk("R6 live subsec", rdSubsec, tick);
        chk("R6 live time", rdTime, liveTime);
        chk("R6 live date", rdDate, liveDate);
      end else begin
        // R6 shadow path, R3 coherence, R2 freshness
        chkShadow("R3");
      end
      if (($urandom % 4) == 0) begin
        pulseClr();
        repeat (45) @(negedge busClk);
        chk("R2 reset flag", syncFlag, 1);
      end
    end
    bypassShadow = 1'b0;

    // R7: sweep the clear across the copy cycle
    hits = 0;
    for (int d = -2; d <= 2; d++) begin
      do pulseClr(); while (syncFlag);
      while (!syncFlag) @(negedge busClk);
      repeat (20 + d - 1) @(negedge busClk);
      pulseClr();
      chk("R7 clear vs copy", syncFlag, (d == 0) ? 1 : 0);
      if (syncFlag) hits++;
    end
    chk("R7 single win", hits, 1);

    // R4: low power stops copies
    @(posedge rtcClk); #2 lowPower = 1'b1;
    repeat (6) @(negedge busClk);
    pulseClr();
    snapS = rdSubsec; snapT = rdTime; snapD = rdDate;
    repeat (6) @(posedge rtcClk);
    @(negedge busClk);
    chk("R4 flag held", syncFlag, 0);
    chk("R4 subsec held", rdSubsec, snapS);
    chk("R4 time held", rdTime, snapT);
    chk("R4 date held", rdDate, snapD);
    // R5: refresh after exit
    @(posedge rtcClk); #2 lowPower = 1'b0;
    #500;
    @(negedge busClk);
    chk("R5 flag back", syncFlag, 1);
    chkShadow("R5");

    // R1: reset again in mid-run
    sysRstN = 1'b0;
    @(negedge busClk);
    chk("R1 re-rst subsec", rdSubsec, 0);
    chk("R1 re-rst flag", syncFlag, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule